// File: doc/BRIEF.md
# DDR2 Command Timing Checker

This block watches the command bus of a DDR2 SDRAM controller. Each clock carries one command slot, made of a command code and a bank number. The block flags any command that arrives before the required minimum spacing from an earlier command has passed. It also flags a bank that has been open longer than the allowed maximum.

Each bank has its own age counters for its last activate, precharge, read and write. Shared counters cover the rules that span banks: activate-to-activate spacing across banks, the rolling four-activate window, column-to-column spacing, and write-to-read turnaround. All limits are parameters in clock cycles. The defaults suit a 2.5 ns clock.

Each rule drives one bit of a violation vector. A bit pulses in the same cycle as the offending command, because it is combinational from the command inputs and the registered ages. A sticky error output collects every pulse and is cleared only by reset. The block is meant to sit beside a controller or a memory model in simulation or on silicon, as a protocol monitor.

Top module: `ddr2_cmd_checker`

## Requirements
- R1: `cmd_i` codes are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge and 5 refresh; codes 6 and 7 act as no-op. A read or write to a bank fewer than T_RCD cycles after that bank's activate raises `viol_o[0]`.
- R2: An activate to a bank fewer than T_RP cycles after that bank's precharge raises `viol_o[1]`.
- R3: `viol_o[2]` rises in two cases: an activate to a bank fewer than T_RC cycles after that bank's previous activate, or a refresh issued while any bank had an activate fewer than T_RC cycles earlier.
- R4: A precharge to a bank fewer than T_RAS cycles after that bank's activate raises `viol_o[3]`.
- R5: When a bank is still open T_RAS_MAX+1 cycles after its activate, `viol_o[4]` pulses for exactly that one cycle. A precharge to that bank closes it, and any command to the bank may arrive in the pulse cycle.
- R6: An activate to a bank other than the most recently activated one, fewer than T_RRD cycles after that activate, raises `viol_o[5]`.
- R7: An activate issued fewer than T_FAW cycles after the fourth most recent activate (any banks) raises `viol_o[6]`.
- R8: A read or write fewer than T_CCD cycles after the previous read or write (any bank) raises `viol_o[7]`.
- R9: A precharge to a bank fewer than BL/2+T_WR cycles after a write to that bank raises `viol_o[8]`. The BL/2 term is the length of the write burst.
- R10: A read fewer than BL/2+T_WTR cycles after the last write to any bank raises `viol_o[9]`.
- R11: A precharge to a bank fewer than T_RTP cycles after a read to that bank raises `viol_o[10]`.
- R12: After reset all violation bits and `err_o` are 0, and every timer reads as long expired. `err_o` rises in the cycle after any violation bit is set and stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, one command slot per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command code (see R1) |
| bank_i | input | $clog2(NBANK) | Bank number of the command |
| viol_o | output | 11 | Per-rule violation pulses, bit positions as in R1 to R11 |
| err_o | output | 1 | Sticky error, cleared only by reset |

## Verification
The assertions make no demand on the command stream, because any code on any bank is legal input to a monitor. They depend on one thing: the age counters are wide enough that T_RAS_MAX+1 lies below their saturation value, and every other limit is smaller than T_RAS_MAX. The bench keeps within this by shortening T_RAS_MAX to 64 and leaving the other limits at their defaults. The random stimulus draws every code, including the two unused ones, on random banks. No-ops are weighted heavily so that command gaps spread across and around each limit.

// File: rtl/ddr2_chk_pkg.sv
package ddr2_chk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;

  localparam int NRULE  = 11;
  localparam int V_RCD  = 0;
  localparam int V_RP   = 1;
  localparam int V_RC   = 2;
  localparam int V_RAS  = 3;
  localparam int V_RMAX = 4;
  localparam int V_RRD  = 5;
  localparam int V_FAW  = 6;
  localparam int V_CCD  = 7;
  localparam int V_WR   = 8;
  localparam int V_WTR  = 9;
  localparam int V_RTP  = 10;

endpackage

// File: rtl/ddr2_gap_cnt.sv
// Saturating age counter: cycles since the last event, reads as max after reset.
module ddr2_gap_cnt #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_i,
  output logic [AW-1:0] age_o
);

  localparam logic [AW-1:0] SAT = '1;

  logic [AW-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= SAT;
    else if (evt_i)       age_q <= AW'(1);
    else if (age_q != SAT) age_q <= age_q + AW'(1);
  end

  assign age_o = age_q;

  a_r12_age_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> age_o >= $past(age_o));

endmodule

// File: rtl/ddr2_faw_win.sv
// Rolling activate window: ages of the last DEPTH activates, newest first.
module ddr2_faw_win #(
  parameter int AW    = 8,
  parameter int DEPTH = 4,
  parameter int T_FAW = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic viol_o
);

  localparam logic [AW-1:0] SAT   = '1;
  localparam logic [AW-1:0] L_FAW = AW'(T_FAW);

  logic [AW-1:0] age_q [DEPTH];

  function automatic logic [AW-1:0] sat_inc(input logic [AW-1:0] a);
    return (a == SAT) ? a : a + AW'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    age_q[i] <= SAT;
        else if (act_i) age_q[i] <= AW'(1);
        else            age_q[i] <= sat_inc(age_q[i]);
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    age_q[i] <= SAT;
        else if (act_i) age_q[i] <= sat_inc(age_q[i-1]);
        else            age_q[i] <= sat_inc(age_q[i]);
      end
      a_r7_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        age_q[i-1] <= age_q[i]);
    end
  end

  // oldest of the last DEPTH activates still inside the window
  assign viol_o = act_i && (age_q[DEPTH-1] < L_FAW);

  a_r7_only_on_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> act_i);

endmodule

// File: rtl/ddr2_bank_trk.sv
// Per-bank row timing state and same-bank rule checks.
module ddr2_bank_trk
  import ddr2_chk_pkg::*;
#(
  parameter int AW        = 15,
  parameter int T_RCD     = 5,
  parameter int T_RP      = 5,
  parameter int T_RC      = 23,
  parameter int T_RAS     = 18,
  parameter int T_RAS_MAX = 28000,
  parameter int WR_GAP    = 8,
  parameter int T_RTP     = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_e cmd_i,
  input  logic hit_i,
  output logic v_rcd_o,
  output logic v_rp_o,
  output logic v_rc_o,
  output logic act_young_o,
  output logic v_ras_o,
  output logic v_rmax_o,
  output logic v_wr_o,
  output logic v_rtp_o
);

  localparam logic [AW-1:0] L_RCD  = AW'(T_RCD);
  localparam logic [AW-1:0] L_RP   = AW'(T_RP);
  localparam logic [AW-1:0] L_RC   = AW'(T_RC);
  localparam logic [AW-1:0] L_RAS  = AW'(T_RAS);
  localparam logic [AW-1:0] L_RMAX = AW'(T_RAS_MAX + 1);
  localparam logic [AW-1:0] L_WR   = AW'(WR_GAP);
  localparam logic [AW-1:0] L_RTP  = AW'(T_RTP);

  logic [AW-1:0] age_act, age_pre, age_rd, age_wr;
  logic is_act, is_pre, is_rd, is_wr, open_q;

  assign is_act = hit_i && (cmd_i == CMD_ACT);
  assign is_pre = hit_i && (cmd_i == CMD_PRE);
  assign is_rd  = hit_i && (cmd_i == CMD_RD);
  assign is_wr  = hit_i && (cmd_i == CMD_WR);

  ddr2_gap_cnt #(.AW(AW)) u_act (.clk_i, .rst_ni, .evt_i(is_act), .age_o(age_act));
  ddr2_gap_cnt #(.AW(AW)) u_pre (.clk_i, .rst_ni, .evt_i(is_pre), .age_o(age_pre));
  ddr2_gap_cnt #(.AW(AW)) u_rd  (.clk_i, .rst_ni, .evt_i(is_rd),  .age_o(age_rd));
  ddr2_gap_cnt #(.AW(AW)) u_wr  (.clk_i, .rst_ni, .evt_i(is_wr),  .age_o(age_wr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     open_q <= 1'b0;
    else if (is_act) open_q <= 1'b1;
    else if (is_pre) open_q <= 1'b0;
  end

  assign v_rcd_o     = (is_rd || is_wr) && (age_act < L_RCD);
  assign v_rp_o      = is_act && (age_pre < L_RP);
  assign v_rc_o      = is_act && (age_act < L_RC);
  assign act_young_o = age_act < L_RC;
  assign v_ras_o     = is_pre && (age_act < L_RAS);
  assign v_rmax_o    = open_q && (age_act == L_RMAX);
  assign v_wr_o      = is_pre && (age_wr < L_WR);
  assign v_rtp_o     = is_pre && (age_rd < L_RTP);

  a_r1_rcd_on_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_rcd_o |-> hit_i && (cmd_i == CMD_RD || cmd_i == CMD_WR));
  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_rmax_o |=> !v_rmax_o);
  a_r4_ras_needs_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_ras_o || v_wr_o || v_rtp_o) |-> cmd_i == CMD_PRE);

endmodule

// File: rtl/ddr2_cmd_checker.sv
module ddr2_cmd_checker
  import ddr2_chk_pkg::*;
#(
  parameter int NBANK     = 4,
  parameter int BL        = 4,
  parameter int T_RCD     = 5,
  parameter int T_RP      = 5,
  parameter int T_RC      = 23,
  parameter int T_RAS     = 18,
  parameter int T_RAS_MAX = 28000,
  parameter int T_RRD     = 3,
  parameter int T_FAW     = 14,
  parameter int T_CCD     = 2,
  parameter int T_WR      = 6,
  parameter int T_WTR     = 3,
  parameter int T_RTP     = 3,
  localparam int BW       = $clog2(NBANK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       cmd_i,
  input  logic [BW-1:0]    bank_i,
  output logic [NRULE-1:0] viol_o,
  output logic             err_o
);

  // counters must outlast the longest limit by two counts
  localparam int AW = $clog2(T_RAS_MAX + 3);
  localparam int WR_GAP  = BL / 2 + T_WR;
  localparam int WTR_GAP = BL / 2 + T_WTR;
  localparam logic [AW-1:0] L_RRD = AW'(T_RRD);
  localparam logic [AW-1:0] L_CCD = AW'(T_CCD);
  localparam logic [AW-1:0] L_WTR = AW'(WTR_GAP);

  cmd_e cmd;
  assign cmd = cmd_e'(cmd_i);

  logic [NBANK-1:0] v_rcd, v_rp, v_rc, young, v_ras, v_rmax, v_wr, v_rtp;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ddr2_bank_trk #(
      .AW(AW), .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_RAS(T_RAS),
      .T_RAS_MAX(T_RAS_MAX), .WR_GAP(WR_GAP), .T_RTP(T_RTP)
    ) u_trk (
      .clk_i, .rst_ni,
      .cmd_i       (cmd),
      .hit_i       (bank_i == BW'(b)),
      .v_rcd_o     (v_rcd[b]),
      .v_rp_o      (v_rp[b]),
      .v_rc_o      (v_rc[b]),
      .act_young_o (young[b]),
      .v_ras_o     (v_ras[b]),
      .v_rmax_o    (v_rmax[b]),
      .v_wr_o      (v_wr[b]),
      .v_rtp_o     (v_rtp[b])
    );
  end

  logic is_act, is_col, is_rd, is_wr;
  assign is_act = cmd == CMD_ACT;
  assign is_rd  = cmd == CMD_RD;
  assign is_wr  = cmd == CMD_WR;
  assign is_col = is_rd || is_wr;

  logic [AW-1:0] age_act_any, age_col_any, age_wr_any;
  ddr2_gap_cnt #(.AW(AW)) u_act_any (.clk_i, .rst_ni, .evt_i(is_act), .age_o(age_act_any));
  ddr2_gap_cnt #(.AW(AW)) u_col_any (.clk_i, .rst_ni, .evt_i(is_col), .age_o(age_col_any));
  ddr2_gap_cnt #(.AW(AW)) u_wr_any  (.clk_i, .rst_ni, .evt_i(is_wr),  .age_o(age_wr_any));

  logic [BW-1:0] last_bank_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_bank_q <= '0;
    else if (is_act) last_bank_q <= bank_i;
  end

  logic v_faw;
  ddr2_faw_win #(.AW(AW), .DEPTH(4), .T_FAW(T_FAW)) u_faw (
    .clk_i, .rst_ni, .act_i(is_act), .viol_o(v_faw)
  );

  always_comb begin
    viol_o         = '0;
    viol_o[V_RCD]  = |v_rcd;
    viol_o[V_RP]   = |v_rp;
    viol_o[V_RC]   = (|v_rc) || ((cmd == CMD_REF) && (|young));
    viol_o[V_RAS]  = |v_ras;
    viol_o[V_RMAX] = |v_rmax;
    viol_o[V_RRD]  = is_act && (bank_i != last_bank_q) && (age_act_any < L_RRD);
    viol_o[V_FAW]  = v_faw;
    viol_o[V_CCD]  = is_col && (age_col_any < L_CCD);
    viol_o[V_WR]   = |v_wr;
    viol_o[V_WTR]  = is_rd && (age_wr_any < L_WTR);
    viol_o[V_RTP]  = |v_rtp;
  end

  logic err_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_q | (|viol_o);
  end
  assign err_o = err_q;

  a_r12_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  a_r12_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|viol_o) |=> err_o);
  a_r6_rrd_on_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o[V_RRD] |-> cmd_i == 3'd1);
  a_r8_ccd_on_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o[V_CCD] |-> (cmd_i == 3'd2 || cmd_i == 3'd3));
  a_r10_wtr_on_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o[V_WTR] |-> cmd_i == 3'd2);

endmodule

// File: tb/sim_ddr2_cmd_checker.sv
module sim_ddr2_cmd_checker;

  localparam int CLK_PERIOD = 10;
  localparam int BL = 4, T_RCD = 5, T_RP = 5, T_RC = 23, T_RAS = 18, T_RAS_MAX = 64;
  localparam int T_RRD = 3, T_FAW = 14, T_CCD = 2, T_WR = 6, T_WTR = 3, T_RTP = 3;
  localparam int NEVER = -1000000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [1:0] bank = 2'd0;
  logic [10:0] viol;
  logic err;

  int nchk = 0, nerr = 0, cyc = 0;
  int t_act[4], t_pre[4], t_rd[4], t_wr[4], t_faw[4];
  bit open_m[4];
  int t_act_any, t_col_any, t_wr_any, last_bank;
  bit err_m;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ddr2_cmd_checker #(
    .NBANK(4), .BL(BL), .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_RAS(T_RAS),
    .T_RAS_MAX(T_RAS_MAX), .T_RRD(T_RRD), .T_FAW(T_FAW), .T_CCD(T_CCD),
    .T_WR(T_WR), .T_WTR(T_WTR), .T_RTP(T_RTP)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .bank_i(bank), .viol_o(viol), .err_o(err)
  );

  function automatic string rtag(input int i);
    case (i)
      0: return "R1";  1: return "R2";  2: return "R3";  3: return "R4";
      4: return "R5";  5: return "R6";  6: return "R7";  7: return "R8";
      8: return "R9";  9: return "R10"; default: return "R11";
    endcase
  endfunction

  function automatic int age(input int t);
    return cyc - t;
  endfunction

  function automatic logic [10:0] exp_viol(input logic [2:0] c, input int b);
    logic [10:0] e = '0;
    bit act = (c == 3'd1), rd = (c == 3'd2), wr = (c == 3'd3), pre = (c == 3'd4);
    bit refr = (c == 3'd5);
    e[0] = (rd || wr) && age(t_act[b]) < T_RCD;
    e[1] = act && age(t_pre[b]) < T_RP;
    e[2] = act && age(t_act[b]) < T_RC;
    for (int k = 0; k < 4; k++) if (refr && age(t_act[k]) < T_RC) e[2] = 1'b1;
    e[3] = pre && age(t_act[b]) < T_RAS;
    for (int k = 0; k < 4; k++) if (open_m[k] && age(t_act[k]) == T_RAS_MAX + 1) e[4] = 1'b1;
    e[5] = act && b != last_bank && age(t_act_any) < T_RRD;
    e[6] = act && age(t_faw[3]) < T_FAW;
    e[7] = (rd || wr) && age(t_col_any) < T_CCD;
    e[8] = pre && age(t_wr[b]) < BL / 2 + T_WR;
    e[9] = rd && age(t_wr_any) < BL / 2 + T_WTR;
    e[10] = pre && age(t_rd[b]) < T_RTP;
    return e;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 4; k++) begin
      t_act[k] = NEVER; t_pre[k] = NEVER; t_rd[k] = NEVER; t_wr[k] = NEVER;
      t_faw[k] = NEVER; open_m[k] = 0;
    end
    t_act_any = NEVER; t_col_any = NEVER; t_wr_any = NEVER; last_bank = 0; err_m = 0;
  endtask

  task automatic model_update(input logic [2:0] c, input int b);
    case (c)
      3'd1: begin
        t_act[b] = cyc; open_m[b] = 1; t_act_any = cyc; last_bank = b;
        t_faw[3] = t_faw[2]; t_faw[2] = t_faw[1]; t_faw[1] = t_faw[0]; t_faw[0] = cyc;
      end
      3'd2: begin t_rd[b] = cyc; t_col_any = cyc; end
      3'd3: begin t_wr[b] = cyc; t_col_any = cyc; t_wr_any = cyc; end
      3'd4: begin t_pre[b] = cyc; open_m[b] = 0; end
      default: ;
    endcase
  endtask

  // one command slot: drive at negedge, check pulses before the edge, update model at edge
  task automatic step(input logic [2:0] c, input int b);
    logic [10:0] e;
    @(negedge clk);
    nchk++;
    if (err !== err_m) begin
      nerr++;
      $display("FAIL R12 err_o got %b exp %b at cyc %0d", err, err_m, cyc);
    end
    cmd = c; bank = 2'(b);
    #1;
    e = exp_viol(c, b);
    for (int i = 0; i < 11; i++) begin
      nchk++;
      if (viol[i] !== e[i]) begin
        nerr++;
        $display("FAIL %s viol_o[%0d] got %b exp %b at cyc %0d cmd %0d bank %0d",
                 rtag(i), i, viol[i], e[i], cyc, c, b);
      end
    end
    @(posedge clk);
    if (|e) err_m = 1;
    model_update(c, b);
    cyc++;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) step(3'd0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    cmd = 3'd0; rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    nchk++;
    if (viol !== 11'd0 || err !== 1'b0) begin
      nerr++;
      $display("FAIL R12 reset state viol=%b err=%b exp 0/0", viol, err);
    end
    rst_n = 1'b1;
  endtask

  task automatic rand_run(input int n);
    for (int i = 0; i < n; i++) begin
      int r = $urandom_range(0, 19);
      logic [2:0] c;
      if (r < 11) c = 3'd0;
      else if (r < 14) c = 3'd1;
      else if (r < 15) c = 3'd2;
      else if (r < 16) c = 3'd3;
      else if (r < 18) c = 3'd4;
      else if (r < 19) c = 3'd5;
      else c = 3'($urandom_range(6, 7));
      step(c, $urandom_range(0, 3));
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    do_reset();
    nops(2);
    // R1 early read, then R8 back-to-back write, R10 read after write
    step(3'd1, 0); nops(3); step(3'd2, 0); step(3'd3, 0); step(3'd2, 0);
    // R4/R9/R11 early precharge, R2/R3 early re-activate
    step(3'd4, 0); step(3'd1, 0);
    // R6 close activates, R7 fifth activate inside window
    step(3'd1, 1); nops(2); step(3'd1, 2); nops(2); step(3'd1, 3); nops(2); step(3'd1, 1);
    // R3 refresh with young activate
    step(3'd5, 0);
    // legal boundaries: RCD, RAS, RP, RC exactly met
    nops(30); step(3'd1, 2); nops(T_RCD - 1); step(3'd2, 2);
    nops(T_RAS - T_RCD - 1); step(3'd4, 2); nops(T_RP - 1); step(3'd1, 2);
    // R5 bank left open past limit
    nops(T_RAS_MAX + 5);
    step(3'd4, 2);
    rand_run(3000);
    do_reset();
    rand_run(3000);
    do_reset();
    nops(4);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule